// File: doc/BRIEF.md
# ECC Error Logger

This block records what an ECC checker reports about failing DRAM accesses. The checker gives it a one-cycle event per failing access. Each event is marked correctable or uncorrectable and carries the access's physical address, an 8-bit syndrome and the number of the channel that took the error. The block keeps one sticky status flag for each error class. It also keeps one set of details for the error it has chosen to keep: the block address, the syndrome and the channel. Software reads these registers, and clears the flags by writing ones to them.

Only one set of details is stored, so the block applies a priority. An uncorrectable error replaces the stored details of a correctable one. A correctable error never replaces the details of an uncorrectable one. Among errors of the same class, the first one is kept until software clears it.

A level output is raised for each class whose enable bit is set in the command register.

The error events are a valid-only stream. The block accepts an event in every cycle and never applies back-pressure, so it has no ready signal.

The register port is plain. The read data is a combinational function of the selected index. A write takes effect at the clock edge.

Register indices on `reg_idx`:

| Index | Register |
|---|---|
| 0 | status |
| 1 | command |
| 2 | address |
| 3 | syndrome |
| 4 | channel |

Indices 5 to 7 read as zero.

Top module: `ecc_err_log`

## Requirements
- R1: A cycle with `ce_evt` high sets status bit 0. A cycle with `ue_evt` high sets status bit 7. Both events in one cycle set both bits. The status register (index 0) reads zero in all other bits.
- R2: A write to index 0 clears status bit 0 and status bit 7 where the written data holds a 1. Where the written data holds a 0, the bit is unchanged.
- R3: The address register (index 2) reads bits 31:12 of the logged access address in bits 31:12, and zero in bits 11:0.
- R4: The syndrome register (index 3) reads the logged 8-bit syndrome in bits 7:0, and zero above.
- R5: The channel register (index 4) reads the logged channel in bit 0, and zero in bits 31:1.
- R6: An uncorrectable event that arrives while no uncorrectable error is logged captures its address, syndrome and channel. This holds even when a correctable error's details are stored.
- R7: While status bit 7 is set, no later event of either class changes the address, syndrome or channel.
- R8: While status bit 0 is set, a later correctable event leaves the address, syndrome and channel unchanged.
- R9: When both event classes arrive in the same cycle with nothing logged, the uncorrectable event's details are stored.
- R10: `err_irq` is high exactly when (status bit 0 AND command bit 7) OR (status bit 7 AND command bit 8). It falls in the cycle after the status bits are cleared.
- R11: An event in the same cycle as a write that clears its own status bit leaves that bit set.
- R12: After reset all registers read zero and `err_irq` is low. The command register (index 1) keeps and reads back only bits 7 and 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_evt | input | 1 | Correctable error event, one cycle per failing access |
| ue_evt | input | 1 | Uncorrectable error event, one cycle per failing access |
| evt_addr | input | 32 | Physical address of the failing access |
| evt_syn | input | 8 | ECC syndrome of the failing access |
| evt_chan | input | 1 | Channel that took the error |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register selected by `reg_idx` |
| err_irq | output | 1 | Level error signal, enabled per error class |

## Verification
A software clear of the status register and a new error event can land in the same clock cycle. The bench provokes this by asserting a correctable event in the same cycle as a write of ones to both status bits. It then reads the status register back: bit 0 must stay set and bit 7 must be clear. A cycle-by-cycle model in the bench judges every read and every `err_irq` sample. The model also covers both event classes arriving in one cycle, where the captured details must be those of the uncorrectable event.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam int IDX_W = 3;
  localparam int NSRC  = 2;            // source 0 correctable, 1 uncorrectable

  typedef enum logic [IDX_W-1:0] {
    RI_STATUS = 3'd0,
    RI_CMD    = 3'd1,
    RI_ADDR   = 3'd2,
    RI_SYN    = 3'd3,
    RI_CHAN   = 3'd4
  } reg_idx_e;

  // bit position of each source in the status register
  function automatic int st_pos(input int src);
    return (src == 0) ? 0 : 7;
  endfunction

  // bit position of each source's enable in the command register
  function automatic int en_pos(input int src);
    return (src == 0) ? 7 : 8;
  endfunction
endpackage

// File: rtl/ecc_log_flag.sv
module ecc_log_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  // R1: an event always leaves the flag set
  assert_flag_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  // R2 / R11: a clear without a same-cycle event drops the flag
  assert_w1c_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);
  // R2: without set or clear the flag holds
  assert_flag_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> $stable(flag_o));
endmodule

// File: rtl/ecc_log_capture.sv
module ecc_log_capture #(
  parameter int ADDR_W  = 32,
  parameter int BLK_LSB = 12,
  parameter int SYN_W   = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ce_i,
  input  logic                      ue_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [SYN_W-1:0]          syn_i,
  input  logic                      chan_i,
  input  logic                      ce_logged_i,
  input  logic                      ue_logged_i,
  output logic [ADDR_W-1:BLK_LSB]   blk_o,
  output logic [SYN_W-1:0]          syn_o,
  output logic                      chan_o
);
  logic take_ue, take_ce, capture;

  // uncorrectable wins over a stored correctable; first of a class wins
  assign take_ue = ue_i && !ue_logged_i;
  assign take_ce = ce_i && !ue_i && !ce_logged_i && !ue_logged_i;
  assign capture = take_ue || take_ce;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_o  <= '0;
      syn_o  <= '0;
      chan_o <= 1'b0;
    end else if (capture) begin
      blk_o  <= addr_i[ADDR_W-1:BLK_LSB];
      syn_o  <= syn_i;
      chan_o <= chan_i;
    end
  end

  // R7: a logged uncorrectable error freezes the details
  assert_ue_details_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ue_logged_i |=> ($stable(blk_o) && $stable(syn_o) && $stable(chan_o)));
  // R8: a logged correctable error is not replaced by another one
  assert_ce_first_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_logged_i && !ue_i) |=> ($stable(blk_o) && $stable(syn_o) && $stable(chan_o)));
  // R6 / R9: a fresh uncorrectable error lands in the details
  assert_ue_overwrites_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_i && !ue_logged_i) |=> (blk_o == $past(addr_i[ADDR_W-1:BLK_LSB]) &&
                                syn_o == $past(syn_i) && chan_o == $past(chan_i)));
endmodule

// File: rtl/ecc_log_regs.sv
module ecc_log_regs
  import ecc_log_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 32,
  parameter int BLK_LSB = 12,
  parameter int SYN_W   = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we_i,
  input  logic [IDX_W-1:0]        idx_i,
  input  logic [DATA_W-1:0]       wdata_i,
  input  logic [NSRC-1:0]         flag_i,
  input  logic [ADDR_W-1:BLK_LSB] blk_i,
  input  logic [SYN_W-1:0]        syn_i,
  input  logic                    chan_i,
  output logic [DATA_W-1:0]       rdata_o,
  output logic                    irq_o
);
  logic [NSRC-1:0]   en_q;
  logic [DATA_W-1:0] st_word, cmd_word;
  logic [NSRC-1:0]   hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else if (we_i && idx_i == RI_CMD)
      for (int s = 0; s < NSRC; s++) en_q[s] <= wdata_i[en_pos(s)];
  end

  always_comb begin
    st_word  = '0;
    cmd_word = '0;
    for (int s = 0; s < NSRC; s++) begin
      st_word[st_pos(s)]  = flag_i[s];
      cmd_word[en_pos(s)] = en_q[s];
    end
  end

  always_comb begin
    case (idx_i)
      RI_STATUS: rdata_o = st_word;
      RI_CMD:    rdata_o = cmd_word;
      RI_ADDR:   rdata_o = DATA_W'({blk_i, {BLK_LSB{1'b0}}});
      RI_SYN:    rdata_o = DATA_W'(syn_i);
      RI_CHAN:   rdata_o = DATA_W'(chan_i);
      default:   rdata_o = '0;
    endcase
  end

  assign hit   = flag_i & en_q;
  assign irq_o = |hit;
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_log_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 32,
  parameter int BLK_LSB = 12,
  parameter int SYN_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_evt,
  input  logic              ue_evt,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic [SYN_W-1:0]  evt_syn,
  input  logic              evt_chan,
  input  logic              reg_we,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              err_irq
);
  logic [NSRC-1:0]         evt_v, flag;
  logic                    st_wr;
  logic [ADDR_W-1:BLK_LSB] blk;
  logic [SYN_W-1:0]        syn;
  logic                    chan;

  assign evt_v = {ue_evt, ce_evt};
  assign st_wr = reg_we && (reg_idx == RI_STATUS);

  for (genvar s = 0; s < NSRC; s++) begin : g_flag
    ecc_log_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (evt_v[s]),
      .clr_i  (st_wr && reg_wdata[st_pos(s)]),
      .flag_o (flag[s])
    );
  end

  ecc_log_capture #(.ADDR_W(ADDR_W), .BLK_LSB(BLK_LSB), .SYN_W(SYN_W)) u_cap (
    .clk         (clk),
    .rst_n       (rst_n),
    .ce_i        (ce_evt),
    .ue_i        (ue_evt),
    .addr_i      (evt_addr),
    .syn_i       (evt_syn),
    .chan_i      (evt_chan),
    .ce_logged_i (flag[0]),
    .ue_logged_i (flag[1]),
    .blk_o       (blk),
    .syn_o       (syn),
    .chan_o      (chan)
  );

  ecc_log_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BLK_LSB(BLK_LSB), .SYN_W(SYN_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (reg_we),
    .idx_i   (reg_idx),
    .wdata_i (reg_wdata),
    .flag_i  (flag),
    .blk_i   (blk),
    .syn_i   (syn),
    .chan_i  (chan),
    .rdata_o (reg_rdata),
    .irq_o   (err_irq)
  );

  // R10: clearing both flags with no new event drops the error signal
  assert_irq_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && reg_wdata[st_pos(0)] && reg_wdata[st_pos(1)] && !ce_evt && !ue_evt) |=> !err_irq);
  // R11: an event beats a same-cycle clear of its own bit
  assert_event_beats_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && ue_evt) |=> reg_idx != RI_STATUS || reg_rdata[st_pos(1)]);
endmodule

// File: tb/tb_ecc_err_log.sv
`timescale 1ns/1ps
module tb_ecc_err_log;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_evt = 0, ue_evt = 0, evt_chan = 0, reg_we = 0;
  logic [31:0] evt_addr = 0, reg_wdata = 0;
  logic [7:0]  evt_syn = 0;
  logic [2:0]  reg_idx = 0;
  logic [31:0] reg_rdata;
  logic        err_irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ecc_err_log dut (
    .clk(clk), .rst_n(rst_n), .ce_evt(ce_evt), .ue_evt(ue_evt),
    .evt_addr(evt_addr), .evt_syn(evt_syn), .evt_chan(evt_chan),
    .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .err_irq(err_irq)
  );

  // behavioural reference model
  bit          m_ce, m_ue, m_en_ce, m_en_ue, m_chan;
  logic [31:0] m_addr;
  logic [7:0]  m_syn;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ce = 0; m_ue = 0; m_en_ce = 0; m_en_ue = 0;
      m_addr = 0; m_syn = 0; m_chan = 0;
    end else begin
      bit keep;
      bit clr_ce, clr_ue;
      keep = 0;
      if (ue_evt && !m_ue) keep = 1;
      else if (ce_evt && !ue_evt && !m_ce && !m_ue) keep = 1;
      if (keep) begin
        m_addr = {evt_addr[31:12], 12'h000};
        m_syn  = evt_syn;
        m_chan = evt_chan;
      end
      clr_ce = reg_we && reg_idx == 0 && reg_wdata[0];
      clr_ue = reg_we && reg_idx == 0 && reg_wdata[7];
      if (ce_evt) m_ce = 1; else if (clr_ce) m_ce = 0;
      if (ue_evt) m_ue = 1; else if (clr_ue) m_ue = 0;
      if (reg_we && reg_idx == 1) begin
        m_en_ce = reg_wdata[7];
        m_en_ue = reg_wdata[8];
      end
    end
  end

  function automatic logic [31:0] exp_rd(input logic [2:0] i);
    case (i)
      3'd0: return {24'h0, m_ue, 6'h0, m_ce};
      3'd1: return {23'h0, m_en_ue, m_en_ce, 7'h0};
      3'd2: return m_addr;
      3'd3: return {24'h0, m_syn};
      3'd4: return {31'h0, m_chan};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag(input logic [2:0] i);
    case (i)
      3'd0: return "R1/R2/R11 status";
      3'd1: return "R12 command";
      3'd2: return "R3/R6/R7/R8/R9 address";
      3'd3: return "R4 syndrome";
      3'd4: return "R5 channel";
      default: return "R12 unused index";
    endcase
  endfunction

  // compared on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [31:0] e;
      bit ei;
      e = exp_rd(reg_idx);
      checks++;
      if (reg_rdata !== e) begin
        errors++;
        $display("FAIL %s idx %0d: actual %h expected %h", tag(reg_idx), reg_idx, reg_rdata, e);
      end
      ei = (m_ce && m_en_ce) || (m_ue && m_en_ue);
      checks++;
      if (err_irq !== ei) begin
        errors++;
        $display("FAIL R10 err_irq: actual %b expected %b", err_irq, ei);
      end
    end
  end

  task automatic step(input bit ce, input bit ue, input logic [31:0] a,
                      input logic [7:0] s, input bit ch, input bit we,
                      input logic [2:0] idx, input logic [31:0] wd);
    @(negedge clk); #1;
    ce_evt = ce; ue_evt = ue; evt_addr = a; evt_syn = s; evt_chan = ch;
    reg_we = we; reg_idx = idx; reg_wdata = wd;
  endtask

  task automatic sweep();
    for (int i = 0; i < 6; i++) step(0, 0, 32'hFFFF_FFFF, 8'hEE, 1, 0, 3'(i), 32'h0);
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    step(0, 0, 0, 0, 0, 1, idx, d);
  endtask

  task automatic evt(input bit ce, input bit ue, input logic [31:0] a,
                     input logic [7:0] s, input bit ch);
    step(ce, ue, a, s, ch, 0, 3'd0, 32'h0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R12 reset state seen at the ports while reset is held
    checks++;
    if (reg_rdata !== 32'h0 || err_irq !== 1'b0) begin
      errors++;
      $display("FAIL R12 reset: actual %h/%b expected 0/0", reg_rdata, err_irq);
    end
    rst_n = 1'b1;
    sweep();
    wr(1, 32'hFFFF_FFFF);                         // R12 only bits 7,8 stick
    sweep();
    evt(1, 0, 32'h1234_5ABC, 8'h3C, 1);           // R1 first CE captured
    sweep();
    evt(1, 0, 32'hAAAA_BFFF, 8'h11, 0);           // R8 second CE ignored
    sweep();
    evt(0, 1, 32'h7654_3210, 8'hC3, 0);           // R6 UE overwrites CE
    sweep();
    evt(1, 0, 32'h0BAD_F00D, 8'h22, 1);           // R7 details frozen
    evt(0, 1, 32'h0DEF_ACED, 8'h44, 1);
    sweep();
    wr(0, 32'hFFFF_FF7E);                         // R2 zeros in bits 0,7 keep flags
    sweep();
    wr(0, 32'h0000_0001);                         // R2 clear CE only
    sweep();
    wr(0, 32'h0000_0080);                         // R2/R10 clear UE, irq drops
    sweep();
    evt(1, 1, 32'h5555_6666, 8'h99, 1);           // R9 both at once
    sweep();
    wr(0, 32'h0000_0081);
    evt(1, 0, 32'h1111_2222, 8'h5A, 0);
    step(1, 0, 32'h3333_4444, 8'hA5, 1, 1, 3'd0, 32'h0000_0081); // R11
    sweep();
    wr(1, 32'h0000_0080);                         // R10 CE enable only
    wr(0, 32'h0000_0081);
    evt(0, 1, 32'h9999_8888, 8'h07, 0);
    sweep();
    wr(1, 32'h0000_0100);                         // R10 UE enable only
    sweep();
    repeat (2) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule